// File: doc/BRIEF.md
# General-Purpose Register Bank with Same-Cycle Write Bypass

This block holds the architectural integer registers of an in-order five-stage processor: 32 words of 32 bits, with two combinational read ports and one write port. The decode stage presents two source-register indices and receives both operand values in the same cycle. The write-back stage presents a destination index, a data word and an enable. The write is stored on the next rising clock edge.

Decode and write-back use the bank in the same cycle. A read index can name the register that write-back is updating in that cycle. In that case the read port returns the incoming write word, not the stale stored word. An instruction in decode therefore sees a result that retires in the same cycle, and the pipeline needs no extra forwarding stage for this case. The destination index always comes from the write-back stage and never from the instruction being decoded.

Register 0 is hard-wired to zero. It ignores writes and is never bypassed. The block has no state machine. Its only sequential state is the register array, which is cleared by an active-low asynchronous reset.

Top module: `gprf_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads as zero on both ports until it is written.
- R2: When `wb_en` is high at a rising edge and `wb_idx` is not 0, `wb_word` is stored in register `wb_idx`. From the next cycle it is read on either port.
- R3: In a cycle where `wb_en` is high, `wb_idx` is not 0 and a read index equals `wb_idx`, that read port outputs `wb_word` combinationally in the same cycle.
- R4: When `wb_en` is low, a read index that equals `wb_idx` returns the stored word, not `wb_word`.
- R5: Register 0 always reads as zero on both ports. A write to index 0 stores nothing. A read of index 0 during such a write returns zero.
- R6: The two read ports are independent. Different indices read in the same cycle each return their own register's value.
- R7: A cycle with `wb_en` low leaves every register unchanged.
- R8: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| src_a_idx | input | 5 | Register index for read port A |
| src_b_idx | input | 5 | Register index for read port B |
| wb_idx | input | 5 | Destination register index from write-back |
| wb_word | input | 32 | Data word to write |
| wb_en | input | 1 | Write enable from write-back |
| src_a_val | output | 32 | Value read on port A |
| src_b_val | output | 32 | Value read on port B |

## Verification
The hardest case to reach is a read that collides with a write in the same cycle. The bypassed value is visible only between the input change and the next rising edge. After that edge, storage holds the same word, so the case cannot be told apart from a plain read. The bench therefore drives the read and write indices together on the falling edge and samples both read ports a nanosecond later, before the write is committed. It loads each target register with a word that differs from the write word, so that a missing or spurious bypass shows up in the output. The same mid-cycle sampling checks the colliding cases with the enable low and with index 0.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    parameter int unsigned GPRF_IDX_W  = 5;
    parameter int unsigned GPRF_WORD_W = 32;

    localparam int unsigned GPRF_RD_PORTS = 2;

endpackage

// File: rtl/gprf_wr_gate.sv
module gprf_wr_gate #(
    parameter int unsigned IW = 5
) (
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    output logic          wr_live
);

    // Writes aimed at the hard-wired zero register are dropped here.
    always_comb begin
        wr_live = wb_en && (wb_idx != '0);
    end

endmodule

// File: rtl/gprf_store.sv
module gprf_store #(
    parameter int unsigned IW = 5,
    parameter int unsigned WW = 32,
    localparam int unsigned CNT = 1 << IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_live,
    input  logic [IW-1:0] wr_idx,
    input  logic [WW-1:0] wr_word,
    output logic [WW-1:0] cells [CNT]
);

    assign cells[0] = '0;

    for (genvar g = 1; g < CNT; g++) begin : g_cell
        logic hit;
        assign hit = wr_live && (wr_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (hit) begin
                cells[g] <= wr_word;
            end
        end
    end

endmodule

// File: rtl/gprf_rdport.sv
module gprf_rdport #(
    parameter int unsigned IW = 5,
    parameter int unsigned WW = 32,
    localparam int unsigned CNT = 1 << IW
) (
    input  logic [WW-1:0] cells [CNT],
    input  logic [IW-1:0] rd_idx,
    input  logic          wr_live,
    input  logic [IW-1:0] wr_idx,
    input  logic [WW-1:0] wr_word,
    output logic [WW-1:0] rd_word
);

    logic collide;

    always_comb begin
        // wr_live is already false for index 0, so zero is never bypassed.
        collide = wr_live && (wr_idx == rd_idx);
        rd_word = collide ? wr_word : cells[rd_idx];
    end

endmodule

// File: rtl/gprf_bank.sv
module gprf_bank #(
    parameter int unsigned IW = gprf_pkg::GPRF_IDX_W,
    parameter int unsigned WW = gprf_pkg::GPRF_WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] src_a_idx,
    input  logic [IW-1:0] src_b_idx,
    input  logic [IW-1:0] wb_idx,
    input  logic [WW-1:0] wb_word,
    input  logic          wb_en,
    output logic [WW-1:0] src_a_val,
    output logic [WW-1:0] src_b_val
);

    localparam int unsigned CNT = 1 << IW;
    localparam int unsigned NRD = gprf_pkg::GPRF_RD_PORTS;

    logic          wr_live;
    logic [WW-1:0] cells [CNT];
    logic [IW-1:0] rd_idx  [NRD];
    logic [WW-1:0] rd_word [NRD];

    assign rd_idx[0] = src_a_idx;
    assign rd_idx[1] = src_b_idx;
    assign src_a_val = rd_word[0];
    assign src_b_val = rd_word[1];

    gprf_wr_gate #(.IW(IW)) u_gate (
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wr_live (wr_live)
    );

    gprf_store #(.IW(IW), .WW(WW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_live (wr_live),
        .wr_idx  (wb_idx),
        .wr_word (wb_word),
        .cells   (cells)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gprf_rdport #(.IW(IW), .WW(WW)) u_port (
            .cells   (cells),
            .rd_idx  (rd_idx[p]),
            .wr_live (wr_live),
            .wr_idx  (wb_idx),
            .wr_word (wb_word),
            .rd_word (rd_word[p])
        );
    end

endmodule

// File: rtl/gprf_bank_chk.sv
module gprf_bank_chk #(
    parameter int unsigned IW = 5,
    parameter int unsigned WW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] src_a_idx,
    input logic [IW-1:0] src_b_idx,
    input logic [IW-1:0] wb_idx,
    input logic [WW-1:0] wb_word,
    input logic          wb_en,
    input logic [WW-1:0] src_a_val,
    input logic [WW-1:0] src_b_val
);

    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    a_r3_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_idx != '0 && src_a_idx == wb_idx) |-> src_a_val == wb_word);

    a_r3_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_idx != '0 && src_b_idx == wb_idx) |-> src_b_val == wb_word);

    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == '0) |-> src_a_val == '0);

    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_idx == '0) |-> src_b_val == '0);

    // R2: a committed write is visible on the next cycle unless overwritten again.
    a_r2_commit_a: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(wb_en) && $past(wb_idx) != '0 && src_a_idx == $past(wb_idx)
         && !(wb_en && wb_idx == src_a_idx)) |-> src_a_val == $past(wb_word));

    a_r2_commit_b: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(wb_en) && $past(wb_idx) != '0 && src_b_idx == $past(wb_idx)
         && !(wb_en && wb_idx == src_b_idx)) |-> src_b_val == $past(wb_word));

    // R4 / R7: with no write in flight, a register read twice in a row holds its value.
    a_r7_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(wb_en) && !wb_en && $stable(src_a_idx)) |-> $stable(src_a_val));

endmodule

bind gprf_bank gprf_bank_chk #(.IW(IW), .WW(WW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a_idx (src_a_idx),
    .src_b_idx (src_b_idx),
    .wb_idx    (wb_idx),
    .wb_word   (wb_word),
    .wb_en     (wb_en),
    .src_a_val (src_a_val),
    .src_b_val (src_b_val)
);

// File: tb/gprf_bank_bench.sv
`timescale 1ns/1ps
module gprf_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_a_idx = '0;
    logic [4:0]  src_b_idx = '0;
    logic [4:0]  wb_idx = '0;
    logic [31:0] wb_word = '0;
    logic        wb_en = 1'b0;
    logic [31:0] src_a_val;
    logic [31:0] src_b_val;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] model [32];

    always #2 clk = ~clk;

    gprf_bank u_gprf_bank (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .wb_idx(wb_idx), .wb_word(wb_word), .wb_en(wb_en),
        .src_a_val(src_a_val), .src_b_val(src_b_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at falling edge, settle, then let the rising edge commit.
    task automatic cycle(input logic en, input logic [4:0] wi, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wb_en = en; wb_idx = wi; wb_word = wd; src_a_idx = ra; src_b_idx = rb;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        if (wb_en && wb_idx != 0) model[wb_idx] = wb_word;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) model[i] = '0;
        for (int i = 0; i < 32; i += 7) begin
            #1;
            src_a_idx = 5'(i); src_b_idx = 5'(31 - i);
            #1;
            check("R1 reset port A", src_a_val, 32'h0);
            check("R1 reset port B", src_b_val, 32'h0);
        end
        @(negedge clk); rst_n = 1'b1;
        cycle(1'b0, 5'd0, '0, 5'd13, 5'd31);
        check("R1 after release A", src_a_val, 32'h0);
        check("R1 after release B", src_b_val, 32'h0);
        commit();
    endtask

    task automatic t_fill_and_read();
        for (int i = 1; i < 32; i++) begin
            cycle(1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'd0, 5'd0);
            commit();
        end
        for (int i = 1; i < 32; i++) begin
            cycle(1'b0, 5'd0, 32'hDEAD_BEEF, 5'(i), 5'(32 - i));
            check("R2 stored port A", src_a_val, model[i]);
            check("R6 independent port B", src_b_val, model[32 - i]);
            commit();
        end
    endtask

    task automatic t_bypass();
        cycle(1'b1, 5'd9, 32'h1234_5678, 5'd9, 5'd9);
        check("R3 bypass A", src_a_val, 32'h1234_5678);
        check("R3 bypass B", src_b_val, 32'h1234_5678);
        commit();
        cycle(1'b1, 5'd20, 32'h0BAD_F00D, 5'd20, 5'd21);
        check("R3 bypass A only", src_a_val, 32'h0BAD_F00D);
        check("R6 port B unaffected", src_b_val, model[21]);
        commit();
        cycle(1'b0, 5'd0, '0, 5'd9, 5'd20);
        check("R2 after bypass A", src_a_val, 32'h1234_5678);
        check("R2 after bypass B", src_b_val, 32'h0BAD_F00D);
        commit();
    endtask

    task automatic t_no_enable();
        logic [31:0] old;
        old = model[5];
        cycle(1'b0, 5'd5, 32'hFFFF_0000, 5'd5, 5'd5);
        check("R4 no bypass A", src_a_val, old);
        check("R4 no bypass B", src_b_val, old);
        commit();
        cycle(1'b0, 5'd0, '0, 5'd5, 5'd6);
        check("R7 unchanged", src_a_val, old);
        check("R7 neighbour", src_b_val, model[6]);
        commit();
    endtask

    task automatic t_zero_reg();
        cycle(1'b1, 5'd0, 32'hCAFE_CAFE, 5'd0, 5'd0);
        check("R5 no bypass to zero A", src_a_val, 32'h0);
        check("R5 no bypass to zero B", src_b_val, 32'h0);
        commit();
        cycle(1'b0, 5'd0, '0, 5'd0, 5'd1);
        check("R5 zero stays zero", src_a_val, 32'h0);
        check("R8 r1 untouched by r0 write", src_b_val, model[1]);
        commit();
    endtask

    task automatic t_isolation();
        cycle(1'b1, 5'd16, 32'h5555_AAAA, 5'd0, 5'd0);
        commit();
        for (int i = 14; i < 19; i++) begin
            cycle(1'b0, 5'd0, '0, 5'(i), 5'(i));
            check("R8 isolation A", src_a_val, model[i]);
            check("R8 isolation B", src_b_val, model[i]);
            commit();
        end
        check("R2 overwrite value", model[16], 32'h5555_AAAA);
    endtask

    initial begin
        t_reset();
        t_fill_and_read();
        t_bypass();
        t_no_enable();
        t_zero_reg();
        t_isolation();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule